// File: doc/BRIEF.md
# Self-Routing Binary Delta Network

This block is a pipelined multistage switch fabric. It connects 2^K input ports to 2^K output ports through K columns of two-input, two-output switching elements. Each input cycle, every port may offer one cell, made of a valid flag, a K-bit destination label and a payload. No central controller computes paths. Each element looks at one bit of the destination label and sends the cell to its even (upper) or odd (lower) output. Between columns, the link indices are permuted by a perfect shuffle, which is a one-bit left rotation of the K-bit link index. Destination bits are used from most significant to least significant. With this wiring, a cell that meets no contention leaves on the output whose index equals its label.

Every delivered cell carries the index of the port it came from. A reply can therefore be steered back through an identical fabric by using that index as its label. Each column has one register stage, so the latency is exactly K cycles and a new set of cells can enter every cycle. The stream interface has valid only. There is no back-pressure: the fabric accepts every offered cell, and the sink must take each output cell in the cycle it is shown. If two cells inside an element want the same output, the upper input keeps it, the other cell is discarded, and a conflict flag for that element is raised for one cycle.

Top module: `delta_route_net`

## Requirements
- R1: A valid cell offered on input x with label y that meets no contention leaves on output port y. Input port i uses in_dst[i*K +: K], and output port j uses out_valid[j].
- R2: A delivered cell shows its unchanged payload on out_data[j*PW +: PW] and its origin index x on out_src[j*K +: K].
- R3: A cell offered before clock edge c is visible on the outputs after edge c+K-1, which is K cycles later. Before that the outputs show nothing from it. A different set of cells may be offered on every cycle.
- R4: Column s (0 = input side) steers by label bit K-1-s. A bit value of 0 picks the even output link 2e of element e, and 1 picks the odd link 2e+1. The upper input of element e is the previous link with index rotr(2e), and the lower input is link rotr(2e+1). Here rotr is a one-bit right rotation of the K-bit index, and column 0 takes the input ports as its links.
- R5: When both inputs of an element are valid and want the same output, the upper input's cell goes through and the lower input's cell is dropped.
- R6: conflict[s*(N/2)+e] is high for exactly one cycle, in the cycle after column s registers a contention in element e. For cells offered before edge c, that is after edge c+s.
- R7: An input whose valid is low injects no cell and causes no conflict, whatever its label and payload.
- R8: While rst_n is low, every out_valid bit and every conflict bit is low.
- R9: For any permutation whose cells meet no contention in this wiring, every cell reaches its labeled output with the correct origin. Identity and cyclic shifts are examples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | N | Cell present on each input port |
| in_dst | input | N*K | Destination label for each input port |
| in_data | input | N*PW | Payload for each input port |
| out_valid | output | N | Cell present on each output port |
| out_src | output | N*K | Origin input index of each output cell |
| out_data | output | N*PW | Payload of each output cell |
| conflict | output | K*N/2 | Per-element contention flag, column-major |

## Verification
The bench builds the fabric with K = 3 and PW = 8. That gives eight ports and three columns of four elements, so a cell can lose at the first, middle or last column, and there are enough distinct permutations for random trials. Directed identity and shift patterns are checked against the permutation alone. Random permutations and random partial loads are checked against a bench model of the shuffle wiring, stage-by-stage flags and drop rule. One back-to-back pair confirms that consecutive offerings pass through one cycle apart.

// File: rtl/dn_pkg.sv
package dn_pkg;
  // Index of the previous-column link that feeds shuffled position j.
  function automatic int shuf_src(input int j, input int k);
    return (j >> 1) | ((j & 1) << (k - 1));
  endfunction
endpackage

// File: rtl/dn_switch.sv
module dn_switch #(
  parameter int PW  = 8,
  parameter int K   = 3,
  parameter int SEL = 0,
  localparam int CW = 1 + 2 * K + PW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] up_i,
  input  logic [CW-1:0] dn_i,
  output logic [CW-1:0] q0_o,
  output logic [CW-1:0] q1_o,
  output logic          conf_o
);
  localparam int VB = CW - 1;
  localparam int DB = PW + K + SEL;

  logic up_v, dn_v, up_b, dn_b, hit;
  logic [CW-1:0] n0, n1;

  assign up_v = up_i[VB];
  assign dn_v = dn_i[VB];
  assign up_b = up_i[DB];
  assign dn_b = dn_i[DB];

  always_comb begin
    n0  = '0;
    n1  = '0;
    hit = up_v && dn_v && (up_b == dn_b);
    if (up_v && !up_b)      n0 = up_i;
    else if (dn_v && !dn_b) n0 = dn_i;
    if (up_v && up_b)       n1 = up_i;
    else if (dn_v && dn_b)  n1 = dn_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q0_o   <= '0;
      q1_o   <= '0;
      conf_o <= 1'b0;
    end else begin
      q0_o   <= n0;
      q1_o   <= n1;
      conf_o <= hit;
    end
  end

  // R4: even link only carries label bit 0, odd link only bit 1
  a_r4_even_link: assert property (@(posedge clk) disable iff (!rst_n)
    q0_o[VB] |-> !q0_o[DB]);
  a_r4_odd_link: assert property (@(posedge clk) disable iff (!rst_n)
    q1_o[VB] |-> q1_o[DB]);
  // R5: on contention the upper cell is what leaves
  a_r5_upper_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (up_v && dn_v && (up_b == dn_b)) |=>
      (($past(up_b) ? q1_o : q0_o) == $past(up_i)));
  // R6: a flagged element delivers exactly one cell
  a_r6_one_survivor: assert property (@(posedge clk) disable iff (!rst_n)
    conf_o |-> ($countones({q0_o[VB], q1_o[VB]}) == 1));
  // R7: idle inputs give idle outputs and no flag
  a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_v && !dn_v) |=> (!q0_o[VB] && !q1_o[VB] && !conf_o));
endmodule

// File: rtl/dn_stage.sv
module dn_stage #(
  parameter int PW = 8,
  parameter int K  = 3,
  parameter int S  = 0,
  localparam int N  = 1 << K,
  localparam int NE = N / 2,
  localparam int CW = 1 + 2 * K + PW
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N-1:0][CW-1:0]  cells_i,
  output logic [N-1:0][CW-1:0]  cells_o,
  output logic [NE-1:0]         conf_o
);
  for (genvar e = 0; e < NE; e++) begin : g_el
    localparam int UA = dn_pkg::shuf_src(2 * e, K);
    localparam int UB = dn_pkg::shuf_src(2 * e + 1, K);
    dn_switch #(.PW(PW), .K(K), .SEL(K - 1 - S)) u_sw (
      .clk   (clk),
      .rst_n (rst_n),
      .up_i  (cells_i[UA]),
      .dn_i  (cells_i[UB]),
      .q0_o  (cells_o[2*e]),
      .q1_o  (cells_o[2*e+1]),
      .conf_o(conf_o[e])
    );
  end
endmodule

// File: rtl/delta_route_net.sv
module delta_route_net #(
  parameter int K  = 3,
  parameter int PW = 8,
  localparam int N  = 1 << K,
  localparam int NE = N / 2,
  localparam int CW = 1 + 2 * K + PW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    in_valid,
  input  logic [N*K-1:0]  in_dst,
  input  logic [N*PW-1:0] in_data,
  output logic [N-1:0]    out_valid,
  output logic [N*K-1:0]  out_src,
  output logic [N*PW-1:0] out_data,
  output logic [K*NE-1:0] conflict
);
  logic [N-1:0][CW-1:0] link [K+1];

  for (genvar i = 0; i < N; i++) begin : g_port
    localparam logic [K-1:0] ORG = K'(i);
    assign link[0][i] = {in_valid[i], in_dst[i*K +: K], ORG, in_data[i*PW +: PW]};
    assign out_valid[i]        = link[K][i][CW-1];
    assign out_src[i*K +: K]   = link[K][i][PW +: K];
    assign out_data[i*PW +: PW] = link[K][i][PW-1:0];

    // R1: every cell on final link i carries label i
    a_r1_label_match: assert property (@(posedge clk) disable iff (!rst_n)
      link[K][i][CW-1] |-> (link[K][i][PW+K +: K] == ORG));
  end

  for (genvar s = 0; s < K; s++) begin : g_col
    dn_stage #(.PW(PW), .K(K), .S(s)) u_st (
      .clk    (clk),
      .rst_n  (rst_n),
      .cells_i(link[s]),
      .cells_o(link[s+1]),
      .conf_o (conflict[s*NE +: NE])
    );
  end
endmodule

// File: tb/sim_delta_route_net.sv
module sim_delta_route_net;
  localparam int K  = 3;
  localparam int PW = 8;
  localparam int N  = 1 << K;
  localparam int NE = N / 2;

  logic clk = 0, rst_n = 0;
  logic [N-1:0]    in_valid = '0;
  logic [N*K-1:0]  in_dst = '0;
  logic [N*PW-1:0] in_data = '0;
  logic [N-1:0]    out_valid;
  logic [N*K-1:0]  out_src;
  logic [N*PW-1:0] out_data;
  logic [K*NE-1:0] conflict;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  delta_route_net #(.K(K), .PW(PW)) u0 (.*);

  // stimulus and model state
  int pv[N], pd[N], pp[N];
  int ev[N], es[N], ep[N];
  int ec[K][NE];
  int nconf;

  function automatic int rotr(int j);
    return (j >> 1) | ((j & 1) << (K - 1));
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // bench model: shuffle wiring, bit-per-column steering, upper wins
  task automatic model();
    int cv[N], cd[N], cs[N], cp[N];
    int nv[N], nd[N], ns[N], np[N];
    nconf = 0;
    for (int i = 0; i < N; i++) begin
      cv[i] = pv[i]; cd[i] = pd[i]; cs[i] = i; cp[i] = pp[i];
    end
    for (int s = 0; s < K; s++) begin
      for (int i = 0; i < N; i++) nv[i] = 0;
      for (int e = 0; e < NE; e++) begin
        int a = rotr(2*e), b = rotr(2*e+1);
        int ba = (cd[a] >> (K-1-s)) & 1, bb = (cd[b] >> (K-1-s)) & 1;
        ec[s][e] = (cv[a] && cv[b] && ba == bb) ? 1 : 0;
        nconf += ec[s][e];
        if (cv[b]) begin
          nv[2*e+bb] = 1; nd[2*e+bb] = cd[b]; ns[2*e+bb] = cs[b]; np[2*e+bb] = cp[b];
        end
        if (cv[a]) begin
          nv[2*e+ba] = 1; nd[2*e+ba] = cd[a]; ns[2*e+ba] = cs[a]; np[2*e+ba] = cp[a];
        end
      end
      for (int i = 0; i < N; i++) begin
        cv[i] = nv[i]; cd[i] = nd[i]; cs[i] = ns[i]; cp[i] = np[i];
      end
    end
    for (int i = 0; i < N; i++) begin
      ev[i] = cv[i]; es[i] = cs[i]; ep[i] = cp[i];
    end
  endtask

  task automatic drive();
    for (int i = 0; i < N; i++) begin
      in_valid[i] = pv[i][0];
      in_dst[i*K +: K] = pv[i] ? pd[i][K-1:0] : K'($urandom);
      in_data[i*PW +: PW] = pp[i][PW-1:0];
    end
  endtask

  task automatic check_outputs(string req);
    for (int j = 0; j < N; j++) begin
      chk(out_valid[j] == ev[j][0], req, $sformatf("valid port %0d", j), out_valid[j], ev[j]);
      if (ev[j]) begin
        chk(out_src[j*K +: K] == es[j][K-1:0], "R2", $sformatf("src port %0d", j),
            out_src[j*K +: K], es[j]);
        chk(out_data[j*PW +: PW] == ep[j][PW-1:0], "R2", $sformatf("data port %0d", j),
            out_data[j*PW +: PW], ep[j]);
      end
    end
  endtask

  // one offering, checked cycle by cycle
  task automatic run_one(string req);
    logic [K*NE-1:0] m;
    model();
    @(negedge clk); drive();
    for (int s = 0; s < K; s++) begin
      @(negedge clk);
      if (s == 0) in_valid = '0;
      m = '0;
      for (int e = 0; e < NE; e++) m[s*NE+e] = ec[s][e][0];
      chk(conflict == m, "R6", $sformatf("flags at column %0d", s), conflict, m);
      if (s < K-1) chk(out_valid == '0, "R3", "early output", out_valid, 0);
    end
    check_outputs(req);
  endtask

  task automatic set_perm(int sh, bit rnd);
    int p[N];
    for (int i = 0; i < N; i++) p[i] = (i + sh) % N;
    if (rnd) for (int i = N-1; i > 0; i--) begin
      int j = $urandom_range(i, 0), t = p[i];
      p[i] = p[j]; p[j] = t;
    end
    for (int i = 0; i < N; i++) begin
      pv[i] = 1; pd[i] = p[i]; pp[i] = $urandom_range(255, 0);
    end
  endtask

  // R9: conflict-free permutations checked from the permutation itself
  task automatic run_free_perm(int sh);
    set_perm(sh, 0);
    @(negedge clk); drive();
    @(negedge clk); in_valid = '0;
    repeat (K-1) @(negedge clk);
    for (int i = 0; i < N; i++) begin
      int y = pd[i];
      chk(out_valid[y] == 1'b1, "R9", $sformatf("shift %0d port %0d", sh, y), out_valid[y], 1);
      chk(out_src[y*K +: K] == K'(i), "R9", $sformatf("shift %0d src", sh), out_src[y*K +: K], i);
      chk(out_data[y*PW +: PW] == pp[i][PW-1:0], "R1", "payload at label", out_data[y*PW +: PW], pp[i]);
    end
    chk(conflict == '0, "R9", "no flag", conflict, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk(out_valid == '0, "R8", "valid in reset", out_valid, 0);
    chk(conflict == '0, "R8", "flags in reset", conflict, 0);
    rst_n = 1;
    @(negedge clk);

    // R9 / R1 directed permutations
    for (int sh = 0; sh < N; sh++) run_free_perm(sh);

    // R7: all idle with junk labels
    for (int i = 0; i < N; i++) begin pv[i] = 0; pd[i] = i; pp[i] = 8'hA5; end
    run_one("R7");

    // R5 directed: inputs 0 and 4 share element 0 of column 0, both label 0
    for (int i = 0; i < N; i++) begin pv[i] = 0; pd[i] = 0; pp[i] = 0; end
    pv[0] = 1; pd[0] = 0; pp[0] = 8'h11;
    pv[4] = 1; pd[4] = 0; pp[4] = 8'h44;
    run_one("R5");
    chk(out_src[0 +: K] == 0, "R5", "upper wins", out_src[0 +: K], 0);

    // R4 single cells to every label from every port
    for (int x = 0; x < N; x++) begin
      for (int i = 0; i < N; i++) begin pv[i] = 0; pd[i] = 0; pp[i] = 0; end
      pv[x] = 1; pd[x] = (x * 3 + 5) % N; pp[x] = x + 16;
      run_one("R4");
    end

    // random permutations and random partial loads (R5, R6, R9)
    for (int t = 0; t < 60; t++) begin
      set_perm(0, 1);
      run_one("R9");
      for (int i = 0; i < N; i++) begin
        pv[i] = ($urandom_range(3, 0) != 0); pd[i] = $urandom_range(N-1, 0);
        pp[i] = $urandom_range(255, 0);
      end
      run_one("R5");
    end

    // R3 back-to-back: shift 1 then shift 2 on consecutive cycles
    begin
      int s1[N], s2[N];
      @(negedge clk);
      set_perm(1, 0); for (int i = 0; i < N; i++) s1[i] = pp[i]; drive();
      @(negedge clk);
      set_perm(2, 0); for (int i = 0; i < N; i++) s2[i] = pp[i]; drive();
      @(negedge clk); in_valid = '0;
      repeat (K-2) @(negedge clk);
      for (int i = 0; i < N; i++)
        chk(out_data[((i+1)%N)*PW +: PW] == s1[i][PW-1:0], "R3", "first of pair",
            out_data[((i+1)%N)*PW +: PW], s1[i]);
      @(negedge clk);
      for (int i = 0; i < N; i++)
        chk(out_data[((i+2)%N)*PW +: PW] == s2[i][PW-1:0], "R3", "second of pair",
            out_data[((i+2)%N)*PW +: PW], s2[i]);
      @(negedge clk);
      chk(out_valid == '0, "R3", "pipeline drained", out_valid, 0);
    end

    // R8: reset mid-flight clears outputs
    set_perm(0, 0);
    @(negedge clk); drive();
    @(negedge clk); rst_n = 0; in_valid = '0;
    #1;
    chk(out_valid == '0, "R8", "valid after reset", out_valid, 0);
    chk(conflict == '0, "R8", "flags after reset", conflict, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule